// File: doc/BRIEF.md
# PCI Parity Generator and Checker

This block handles even parity for one 32-bit PCI bus segment. The parity covers the multiplexed address/data lines, the four command/byte-enable lines and PAR, so that the total number of ones is even. The block watches the bus phase qualifiers every clock. It registers the AD and C/BE# values of the current cycle, and in the next clock it either drives PAR or compares it against the PAR that another agent drove.

The block generates PAR whenever it owns the AD lines. That covers read data it returns as a target, addresses and write data it issues as an initiator, and bus parking while its grant is held on an idle bus. It checks PAR when another agent owns AD, both on address phases and on completed data phases. A mismatch produces a single-clock pulse on the matching error output. The surrounding bus interface consumes these pulses, along with PAR and its output enable.

Top module: `pci_parity_unit`

## Requirements
- R1: When PAR is driven, `par_out` equals the XOR of the 32 AD bits and 4 C/BE# bits sampled one clock earlier, so the 37 bits together hold an even count of ones.
- R2: `par_oe` is high in the clock after `ad_oe` was high, and it is low in the clock after a cycle in which the block neither drove AD nor parked. The PAR driver therefore follows the AD driver on and off with one clock of lag.
- R3: When `grant` is high while `frame_n` and `irdy_n` are both high (idle bus), PAR is driven with valid parity in the next clock even if `ad_oe` is low.
- R4: An address phase is a clock in which `frame_n` is low after being high in the previous clock and `ad_oe` is low. In the clock that follows it, `addr_perr` is high exactly when `par_in` disagrees with the parity of that phase's AD/C/BE#.
- R5: A completed data phase is a clock in which `irdy_n` and `trdy_n` are both low and `ad_oe` is low. In the following clock, `data_perr` is high exactly when `par_in` disagrees with that phase's parity.
- R6: A wait-state cycle (`irdy_n` or `trdy_n` high), or any cycle in which the block drives AD, raises no error in the next clock, whatever `par_in` carries.
- R7: While `frame_n` stays low from one clock to the next, no address check is made, so `addr_perr` lasts one clock per address phase.
- R8: While `rst_n` is low, `par_oe`, `addr_perr` and `data_perr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# as seen on the bus |
| irdy_n | input | 1 | IRDY# as seen on the bus |
| trdy_n | input | 1 | TRDY# as seen on the bus |
| ad_oe | input | 1 | Block drives AD in this clock |
| grant | input | 1 | Bus grant to this block (parking) |
| ad_in | input | 32 | AD value on the bus |
| cbe_in | input | 4 | C/BE# value on the bus |
| par_in | input | 1 | PAR value on the bus |
| par_out | output | 1 | Generated PAR |
| par_oe | output | 1 | PAR output enable |
| addr_perr | output | 1 | One-clock address parity error pulse |
| data_perr | output | 1 | One-clock data parity error pulse |

## Verification
Several relations are checked on every cycle. These include the parity of the driven PAR against the previous clock's bus value and the one-clock lag of the PAR enable behind the AD enable. They also include that an error pulse is only ever preceded by a matching address or completed data phase, and that no error is raised while the block itself drives PAR. Other behaviours only show up in the bench's scenarios. Those are the polarity of each check against good and bad parity over several bit patterns, a continuing FRAME# not re-triggering the address check, wait states being skipped, and parking turning the driver on.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            ad_oe,
  input  logic            grant,
  input  logic [AD_W-1:0] ad_in,
  input  logic [AD_W/8-1:0] cbe_in,
  input  logic            par_in,
  output logic            par_out,
  output logic            par_oe,
  output logic            addr_perr,
  output logic            data_perr
);
  localparam int CBE_W = AD_W / 8;

  logic [AD_W-1:0]  ad_q;
  logic [CBE_W-1:0] cbe_q;
  logic             frame_q, drv_q, aph_q, dph_q;
  logic             park, addr_ph, data_ph, calc, mismatch;

  assign park    = grant & frame_n & irdy_n;
  assign addr_ph = ~frame_n & frame_q & ~ad_oe;
  assign data_ph = ~irdy_n & ~trdy_n & ~ad_oe;

  always_ff @(posedge clk) begin
    ad_q  <= ad_in;
    cbe_q <= cbe_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      drv_q   <= 1'b0;
      aph_q   <= 1'b0;
      dph_q   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      drv_q   <= ad_oe | park;
      aph_q   <= addr_ph;
      dph_q   <= data_ph;
    end
  end

  assign calc      = ^{ad_q, cbe_q};
  assign mismatch  = calc ^ par_in;
  assign par_out   = calc;
  assign par_oe    = drv_q;
  assign addr_perr = aph_q & mismatch;
  assign data_perr = dph_q & mismatch;

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (par_out == ^$past({ad_in, cbe_in}))); // R1
  AST_OE_ON_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> par_oe); // R2
  AST_OE_OFF_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!ad_oe && !(grant && frame_n && irdy_n)) |=> !par_oe); // R2
  AST_PARK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && frame_n && irdy_n) |=> par_oe); // R3
  AST_ADDR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_perr |-> $past(!frame_n && !ad_oe)); // R4
  AST_DATA_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    data_perr |-> $past(!irdy_n && !trdy_n && !ad_oe)); // R5
  AST_NO_ERR_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> !(addr_perr || data_perr)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(par_oe || addr_perr || data_perr)); // R8
endmodule

// File: tb/test_pci_parity_unit.sv
`timescale 1ns/1ps
module test_pci_parity_unit;
  logic clk = 0, rst_n = 0;
  logic frame_n = 1, irdy_n = 1, trdy_n = 1, ad_oe = 0, grant = 0, par_in = 0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_in = '0;
  logic par_out, par_oe, addr_perr, data_perr;
  int runs = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_parity_unit i_pci_parity_unit (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .ad_oe(ad_oe), .grant(grant), .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in),
    .par_out(par_out), .par_oe(par_oe), .addr_perr(addr_perr), .data_perr(data_perr));

  function automatic logic evp(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += a[i];
    for (int i = 0; i < 4; i++) n += c[i];
    return n[0];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    frame_n = 1; irdy_n = 1; trdy_n = 1; ad_oe = 0; grant = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R8 par_oe", par_oe, 1'b0);
    chk("R8 addr_perr", addr_perr, 1'b0);
    chk("R8 data_perr", data_perr, 1'b0);
    step(); rst_n = 1; idle(); step();
  endtask

  task automatic t_gen(input logic [31:0] a, input logic [3:0] c);
    idle(); frame_n = 0; irdy_n = 0; trdy_n = 0; ad_oe = 1; ad_in = a; cbe_in = c;
    par_in = ~evp(a, c);
    step();
    idle(); ad_in = ~a; par_in = 1'b0; #1;
    chk("R2 par_oe on", par_oe, 1'b1);
    chk("R1 par_out", par_out, evp(a, c));
    chk("R6 no data_perr when driving", data_perr, 1'b0);
    step(); #1;
    chk("R2 par_oe off", par_oe, 1'b0);
  endtask

  task automatic t_park(input logic [31:0] a, input logic [3:0] c);
    idle(); grant = 1; ad_in = a; cbe_in = c;
    step();
    grant = 0; #1;
    chk("R3 park par_oe", par_oe, 1'b1);
    chk("R3 park par_out", par_out, evp(a, c));
    step(); #1;
    chk("R2 park release", par_oe, 1'b0);
  endtask

  task automatic t_addr(input logic [31:0] a, input logic [3:0] c, input logic bad);
    idle(); step();
    frame_n = 0; ad_in = a; cbe_in = c;
    step();
    ad_in = ~a; par_in = evp(a, c) ^ bad; #1;
    chk("R4 addr_perr", addr_perr, bad);
    chk("R4 no data_perr", data_perr, 1'b0);
    chk("R2 target side par_oe", par_oe, 1'b0);
    step();
    par_in = ~evp(~a, c); #1;
    chk("R7 frame held no recheck", addr_perr, 1'b0);
    idle(); step();
  endtask

  task automatic t_data(input logic [31:0] a, input logic [3:0] c, input logic bad,
                        input logic ir, input logic tr);
    idle(); frame_n = 0; step();
    irdy_n = ir; trdy_n = tr; ad_in = a; cbe_in = c;
    step();
    irdy_n = 1; trdy_n = 1; par_in = evp(a, c) ^ bad; #1;
    chk((!ir && !tr) ? "R5 data_perr" : "R6 wait state no check",
        data_perr, bad & !ir & !tr);
    chk("R7 no addr_perr in data", addr_perr, 1'b0);
    idle(); step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gen(32'h0000_0000, 4'h0);
    t_gen(32'hFFFF_FFFF, 4'h7);
    t_gen(32'h1234_5678, 4'hA);
    t_gen(32'h8000_0001, 4'h1);
    t_park(32'hDEAD_BEEF, 4'hC);
    t_park(32'h0000_0001, 4'h0);
    t_addr(32'hA5A5_0001, 4'h6, 1'b0);
    t_addr(32'hA5A5_0001, 4'h6, 1'b1);
    t_addr(32'h0F0F_F0F0, 4'hB, 1'b1);
    t_data(32'h1111_2222, 4'h0, 1'b0, 1'b0, 1'b0);
    t_data(32'h1111_2223, 4'h3, 1'b1, 1'b0, 1'b0);
    t_data(32'h7654_3210, 4'hF, 1'b1, 1'b1, 1'b0);
    t_data(32'h7654_3210, 4'hF, 1'b1, 1'b0, 1'b1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule